// File: doc/BRIEF.md
# Dual-Port Display Selection Controller

This block is the control core of a video switch that routes one display source to one of two output connectors. It decides which connector's path is enabled, and it drives an active-low, open-drain status line that tells the system whether a display is attached at the chosen connector. The status line is modelled here as a drive-low enable. The analog switches, the level shifting and the sensing of display termination are outside the block. It receives one debounced, clock-synchronous presence flag per connector.

The block has two ways of choosing. In manual mode the select level names the connector directly. In automatic mode the connector comes from the presence flags, and the same pin acts as a tie-breaker. Once a connector has been chosen, the choice is latched. It is reconsidered only after one of a small set of events: the display on the chosen connector goes away, the mode level changes, the select level changes, or the block is disabled and then enabled again. A path change always passes through one clock in which neither path is enabled.

Top module: `dual_port_display_select`

## Requirements
- R1: While reset is held and for `BOOT_CYCLES` clocks after its release, both path enables are 0 and the status drive is 0. The first path enable rises exactly `BOOT_CYCLES`+1 clocks after reset release. `pathEn[0]` is connector 1 and `pathEn[1]` is connector 2.
- R2: With `modeSel` high (manual mode), a re-evaluation enables connector 1 when `prioSel` is 0 and connector 2 when `prioSel` is 1, whatever the presence flags are. `monPresent[0]` belongs to connector 1 and `monPresent[1]` to connector 2.
- R3: With `modeSel` low (automatic mode) and exactly one presence flag set, a re-evaluation enables that connector, whatever `prioSel` is.
- R4: In automatic mode with both flags set, a re-evaluation enables connector 1 when `prioSel` is 0 and connector 2 when it is 1.
- R5: In automatic mode with no flag set, a re-evaluation enables the connector named by `prioSel`, and the status drive stays 0.
- R6: `statusDriveLow` is 1 exactly when a path is enabled and the presence flag of that connector is 1. It follows a flag change in the same cycle.
- R7: When `chipEnN` is high, both enables and the status drive are 0 from the next clock on. After `chipEnN` returns low, the block re-evaluates and enables a path two clocks later.
- R8: The block re-evaluates on three events. A fall of the chosen connector's flag starts a re-evaluation on the next clock. A change of `modeSel` or `prioSel` starts one three clocks after the change, because two synchronizer stages come first. Before that point the enables do not change.
- R9: Between events, a change of the other connector's flag never changes the enabled path.
- R10: At most one enable is 1 at any time. When a re-evaluation picks a new connector, both enables are 0 for exactly one clock before the new one rises. When it picks the same connector, the enable never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| chipEnN | input | 1 | Active-low enable; high disables both paths |
| modeSel | input | 1 | 0 = automatic choice, 1 = manual choice (synchronized) |
| prioSel | input | 1 | Priority in automatic mode, select in manual mode (synchronized) |
| monPresent | input | 2 | Debounced presence flag per connector, bit 0 = connector 1 |
| pathEn | output | 2 | Path enable per connector, bit 0 = connector 1 |
| statusDriveLow | output | 1 | 1 pulls the open-drain status line low |

## Verification
If the latched choice register is wrong, it shows at once on `pathEn`. The stimulus reads that choice back as the enabled path after each event, so an error appears within the clocks of the event. If the event snapshot of mode or priority is wrong, the fault shows differently: the block either re-evaluates when it should not, or never re-evaluates. Each event therefore has its enable pattern checked at the exact clock of the old path's fall, the empty gap and the new path's rise, and checked again several clocks later. If the presence flag of the wrong connector feeds the status drive, `statusDriveLow` disagrees in the same cycle as the flag change.

// File: rtl/dps_pkg.sv
package dps_pkg;

  // Index of each connector inside monPresent / pathEn
  localparam int NUM_PORTS = 2;

  typedef enum logic [2:0] {
    ST_BOOT = 3'd0,
    ST_EVAL = 3'd1,
    ST_GAP  = 3'd2,
    ST_HOLD = 3'd3,
    ST_OFF  = 3'd4
  } selState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearPath;  // drop the enabled path
    logic loadPath;   // latch portSel and enable it
    logic portSel;    // 0 = connector 1, 1 = connector 2
  } selStrobe_t;

endpackage

// File: rtl/dps_sync.sv
module dps_sync #(
  parameter int WIDTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stg [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= asyncIn;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= '0;
      else       stg[i] <= stg[i-1];
    end
  end

  assign syncOut = stg[SYNC_STAGES-1];

endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int BOOT_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipEnN,
  input  logic                 syncMode,
  input  logic                 syncPrio,
  input  logic [NUM_PORTS-1:0] monPresent,
  input  logic                 pathOn,
  input  logic                 curPort,
  output selStrobe_t           strb
);

  localparam int CNT_W = $clog2(BOOT_CYCLES + 1);
  localparam logic [CNT_W-1:0] BOOT_LAST = CNT_W'(BOOT_CYCLES - 1);

  selState_t state, nextState;
  logic [CNT_W-1:0] bootCnt;
  logic lastMode, lastPrio;
  logic chosenPrev, wasHold;
  logic wantPort, chosenLost, reEval;

  // Port the current inputs ask for
  always_comb begin
    if (syncMode)                 wantPort = syncPrio;
    else if (monPresent == 2'b01) wantPort = 1'b0;
    else if (monPresent == 2'b10) wantPort = 1'b1;
    else                          wantPort = syncPrio;
  end

  assign chosenLost = wasHold & chosenPrev & ~monPresent[curPort];
  assign reEval = chosenLost | (syncMode != lastMode) | (syncPrio != lastPrio);

  always_comb begin
    nextState = state;
    strb      = '0;
    if (state == ST_BOOT) begin
      if (bootCnt == BOOT_LAST) nextState = ST_EVAL;
    end else if (chipEnN) begin
      strb.clearPath = 1'b1;
      nextState      = ST_OFF;
    end else begin
      unique case (state)
        ST_EVAL: begin
          if (pathOn && (wantPort != curPort)) begin
            strb.clearPath = 1'b1;
            nextState      = ST_GAP;
          end else begin
            strb.loadPath = 1'b1;
            strb.portSel  = wantPort;
            nextState     = ST_HOLD;
          end
        end
        ST_GAP: begin
          strb.loadPath = 1'b1;
          strb.portSel  = wantPort;
          nextState     = ST_HOLD;
        end
        ST_HOLD: if (reEval) nextState = ST_EVAL;
        ST_OFF:  nextState = ST_EVAL;
        default: nextState = ST_EVAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_BOOT;
      bootCnt    <= '0;
      lastMode   <= 1'b0;
      lastPrio   <= 1'b0;
      chosenPrev <= 1'b0;
      wasHold    <= 1'b0;
    end else begin
      state      <= nextState;
      chosenPrev <= monPresent[curPort];
      wasHold    <= (state == ST_HOLD);
      if (state == ST_BOOT) bootCnt <= bootCnt + 1'b1;
      if (strb.loadPath) begin
        lastMode <= syncMode;
        lastPrio <= syncPrio;
      end
    end
  end

  // R1: boot phase never outlasts its window
  p_boot_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BOOT) |-> (bootCnt < CNT_W'(BOOT_CYCLES)))
    else $error("boot window exceeded");

  // R8: a synchronized level differing from its snapshot leaves HOLD
  p_level_event_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !chipEnN && (syncPrio != lastPrio)) |=> (state == ST_EVAL))
    else $error("priority change not acted on");

endmodule

// File: rtl/dps_path.sv
module dps_path
  import dps_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  selStrobe_t           strb,
  input  logic [NUM_PORTS-1:0] monPresent,
  output logic                 pathOn,
  output logic                 curPort,
  output logic [NUM_PORTS-1:0] pathEn,
  output logic                 statusDriveLow
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pathOn  <= 1'b0;
      curPort <= 1'b0;
    end else if (strb.clearPath) begin
      pathOn <= 1'b0;
    end else if (strb.loadPath) begin
      pathOn  <= 1'b1;
      curPort <= strb.portSel;
    end
  end

  assign pathEn[0]      = pathOn & ~curPort;
  assign pathEn[1]      = pathOn &  curPort;
  assign statusDriveLow = pathOn & monPresent[curPort];

  // R10: at most one connector driven
  p_onehot_path_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pathEn))
    else $error("two paths enabled");

  // R10: control never loads a different port over a live path
  p_gap_before_switch_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadPath && pathOn) |-> (strb.portSel == curPort))
    else $error("port switched without gap");

endmodule

// File: rtl/dual_port_display_select.sv
module dual_port_display_select
  import dps_pkg::*;
#(
  parameter int BOOT_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEnN,
  input  logic       modeSel,
  input  logic       prioSel,
  input  logic [1:0] monPresent,
  output logic [1:0] pathEn,
  output logic       statusDriveLow
);

  logic [1:0] syncLvl;
  logic       pathOn, curPort;
  selStrobe_t strb;

  dps_sync #(.WIDTH(2), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({modeSel, prioSel}),
    .syncOut (syncLvl)
  );

  dps_ctrl #(.BOOT_CYCLES(BOOT_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chipEnN    (chipEnN),
    .syncMode   (syncLvl[1]),
    .syncPrio   (syncLvl[0]),
    .monPresent (monPresent),
    .pathOn     (pathOn),
    .curPort    (curPort),
    .strb       (strb)
  );

  dps_path u_path (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .monPresent     (monPresent),
    .pathOn         (pathOn),
    .curPort        (curPort),
    .pathEn         (pathEn),
    .statusDriveLow (statusDriveLow)
  );

  // R7: disabled block drives nothing one clock later
  p_chip_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    chipEnN |=> (pathEn == 2'b00 && !statusDriveLow))
    else $error("path active while disabled");

  // R6: status only for a present display on the enabled path
  p_status_on_chosen_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusDriveLow |-> ((pathEn[0] && monPresent[0]) || (pathEn[1] && monPresent[1])))
    else $error("status without display");

  // R10: an enabled path is either kept or dropped, never swapped directly
  p_no_direct_swap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pathEn != 2'b00) |=> (pathEn == 2'b00 || $stable(pathEn)))
    else $error("direct path swap");

endmodule

// File: tb/tb_dual_port_display_select.sv
module tb_dual_port_display_select;

  localparam int BOOT = 4;

  logic clk = 1'b0;
  logic rstN, chipEnN, modeSel, prioSel;
  logic [1:0] monPresent;
  logic [1:0] pathEn;
  logic statusDriveLow;

  always #4 clk = ~clk;  // 125 MHz

  dual_port_display_select #(.BOOT_CYCLES(BOOT), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .modeSel(modeSel),
    .prioSel(prioSel), .monPresent(monPresent),
    .pathEn(pathEn), .statusDriveLow(statusDriveLow)
  );

  typedef struct {
    int         cyc;
    logic [1:0] en;
    logic       st;
    string      req;
  } expItem_t;

  expItem_t q[$];
  int cyc = 0;
  int baseCyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expectAt(int k, logic [1:0] en, logic st, string req);
    expItem_t it;
    it.cyc = baseCyc + k;
    it.en  = en;
    it.st  = st;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mark();
    baseCyc = cyc;
  endtask

  // Monitor: compares results against the queue, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        expItem_t it;
        it = q.pop_front();
        checks++;
        if (it.cyc != cyc || pathEn !== it.en || statusDriveLow !== it.st) begin
          failures++;
          $display("FAIL %s cyc=%0d: pathEn=%b status=%b expected pathEn=%b status=%b",
                   it.req, it.cyc, pathEn, statusDriveLow, it.en, it.st);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Driver
  initial begin
    rstN = 1'b0; chipEnN = 1'b0; modeSel = 1'b0; prioSel = 1'b0; monPresent = 2'b00;
    @(negedge clk); mark();
    expectAt(0, 2'b00, 1'b0, "R1 in reset");
    waitCyc(3);
    rstN = 1'b1; mark();
    expectAt(1, 2'b00, 1'b0, "R1 boot quiet");
    expectAt(BOOT, 2'b00, 1'b0, "R1 boot last");
    expectAt(BOOT + 1, 2'b01, 1'b0, "R1 R5 first enable");
    waitCyc(BOOT + 4);

    monPresent = 2'b01; mark();                      // R6
    expectAt(0, 2'b01, 1'b1, "R6 status same cycle");
    waitCyc(4);

    monPresent = 2'b11; mark();                      // R9
    expectAt(0, 2'b01, 1'b1, "R9 other plug");
    expectAt(6, 2'b01, 1'b1, "R9 other plug held");
    waitCyc(8);

    monPresent = 2'b10; mark();                      // R8 R3 R10
    expectAt(0, 2'b01, 1'b0, "R6 chosen unplug");
    expectAt(1, 2'b01, 1'b0, "R8 eval cycle");
    expectAt(2, 2'b00, 1'b0, "R10 gap");
    expectAt(3, 2'b10, 1'b1, "R3 R8 single present");
    waitCyc(6);

    monPresent = 2'b11; mark();
    expectAt(6, 2'b10, 1'b1, "R9 replug held");
    waitCyc(8);

    prioSel = 1'b1; mark();                          // same port, no gap
    expectAt(3, 2'b10, 1'b1, "R10 no gap same");
    expectAt(4, 2'b10, 1'b1, "R10 no gap same");
    expectAt(5, 2'b10, 1'b1, "R4 prio high");
    waitCyc(7);

    prioSel = 1'b0; mark();
    expectAt(3, 2'b10, 1'b1, "R8 sync delay");
    expectAt(4, 2'b00, 1'b0, "R10 gap prio");
    expectAt(5, 2'b01, 1'b1, "R4 prio low");
    waitCyc(7);

    monPresent = 2'b01; mark();
    expectAt(4, 2'b01, 1'b1, "R9 other unplug");
    waitCyc(6);
    prioSel = 1'b1; mark();
    expectAt(4, 2'b01, 1'b1, "R3 prio ignored");
    expectAt(5, 2'b01, 1'b1, "R3 prio ignored");
    waitCyc(7);

    modeSel = 1'b1; mark();                          // manual, prio 1
    expectAt(3, 2'b01, 1'b1, "R8 mode sync delay");
    expectAt(4, 2'b00, 1'b0, "R10 gap mode");
    expectAt(5, 2'b10, 1'b0, "R2 manual port2");
    waitCyc(7);

    prioSel = 1'b0; mark();
    expectAt(4, 2'b00, 1'b0, "R10 gap manual");
    expectAt(5, 2'b01, 1'b1, "R2 manual port1");
    waitCyc(7);

    chipEnN = 1'b1; mark();
    expectAt(0, 2'b01, 1'b1, "R7 before edge");
    expectAt(1, 2'b00, 1'b0, "R7 disabled");
    expectAt(3, 2'b00, 1'b0, "R7 stays off");
    waitCyc(5);
    chipEnN = 1'b0; mark();
    expectAt(1, 2'b00, 1'b0, "R7 eval");
    expectAt(2, 2'b01, 1'b1, "R7 re-enabled");
    waitCyc(5);

    monPresent = 2'b00; mark();                      // manual disconnect
    expectAt(0, 2'b01, 1'b0, "R6 release");
    expectAt(2, 2'b01, 1'b0, "R8 R10 manual re-eval no gap");
    expectAt(3, 2'b01, 1'b0, "R2 manual keeps port");
    waitCyc(6);

    modeSel = 1'b0; prioSel = 1'b1; mark();
    expectAt(4, 2'b00, 1'b0, "R10 gap auto none");
    expectAt(5, 2'b10, 1'b0, "R5 none present prio");
    waitCyc(7);

    if (q.size() != 0) begin
      failures++;
      checks++;
      $display("FAIL R1 queue: %0d results unchecked, expected 0", q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule